// File: doc/BRIEF.md
# Command-Driven Status and Error Flag Register

This block keeps the operating state of a serial controller together with its sticky error flags. Software never writes the flags directly. It writes a command word in which each flag owns a dedicated set bit and a dedicated clear bit. A command bit that is zero leaves its flag alone, so each write changes only the flags it names and needs no read-modify-write.

Two of the held bits are control state. The enable bit selects configuration mode (0) or active mode (1). The master-select bit chooses the bus role. The other six bits are error flags: mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Hardware sets an error flag with a one-cycle event pulse. Each error flag except mode error has its own gate input that decides whether hardware may set it. A single level interrupt is raised while any error flag is set.

The status word places enable at bit 0 and master-select at bit 1. Mode error is at bit 7. The five gated error flags are at bits 8 to 12, and an externally supplied busy bit is at bit 13. The bus decode and the logic that produces the events sit outside this block.

Top module: `flag_cmd_status`

## Requirements
- R1: While reset is asserted, and directly after it, every held bit reads 0. This means configuration mode, master-select cleared, no error flags set and `err_irq` low.
- R2: A command write with bit 1 set sets enable and one with bit 0 set clears it. Bit 3 sets master-select and bit 2 clears it. The results appear at status bits 0 and 1 after the next clock edge.
- R3: Each error flag has its own command bits:
  - mode error: set on bit 7, clear on bit 6
  - transmit overflow: set on bit 12, clear on bit 8
  - receive overflow: set on bit 13, clear on bit 9
  - abort: set on bit 14, clear on bit 10
  - transmit underflow: set on bit 15, clear on bit 11
  - receive underflow: set on bit 5, clear on bit 4
  
  These flags read back at status bits 7, 8, 9, 10, 11 and 12 in the order given.
- R4: When one write carries both the set bit and the clear bit of the same flag, the flag ends up cleared.
- R5: Error flags are sticky. A flag stays set until a command write carries its own clear bit, whatever else is written or happens.
- R6: Hardware event input `hw_evt` is ordered mode error, transmit overflow, receive overflow, abort, transmit underflow, receive underflow (bits 0 to 5). An event pulse sets its flag on the next edge. Mode error is always accepted. The event at `hw_evt[k]` (k = 1..5) is accepted only while `hw_gate[k-1]` is 1.
- R7: An accepted hardware event and a software clear of the same flag in the same cycle leave the flag set.
- R8: `err_irq` is high exactly while at least one of the six error flags is set. Enable and master-select never affect it.
- R9: Status bit 13 follows `busy_in` in the same cycle. Status bits 2 to 6, 14 and 15 always read 0.
- R10: Command data presented while `cmd_we` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one cycle per write |
| cmd_wdata | input | 16 | Command word of set/clear bit pairs |
| hw_evt | input | 6 | Hardware error event pulses |
| hw_gate | input | 5 | Per-flag hardware set enables for flags 1..5 |
| busy_in | input | 1 | Busy indication shown in status |
| status | output | 16 | Status word |
| err_irq | output | 1 | Level error interrupt |

## Verification
A software command and a hardware event pulse can reach the same flag in the same clock cycle. So can the set bit and the clear bit of one flag within a single command word. The bench drives a clear command together with a gated event for transmit overflow, and again for receive underflow, and expects the flag to read set. It writes words that carry both halves of a pair, including a pattern of alternating bits, and expects cleared flags. Each of these results is judged from the status word one edge later, along with the interrupt level.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int CMD_W  = 16;
    localparam int STAT_W = 16;
    localparam int ERR_N  = 6;
    localparam int FLAG_N = ERR_N + 2;
    localparam int GATE_N = ERR_N - 1;

    // flag index: 0 enable, 1 master-select, 2..7 error flags 0..5
    localparam int SET_POS [FLAG_N] = '{1, 3, 7, 12, 13, 14, 15, 5};
    localparam int CLR_POS [FLAG_N] = '{0, 2, 6, 8, 9, 10, 11, 4};

    localparam int ST_EN   = 0;
    localparam int ST_MS   = 1;
    localparam int ST_MODE = 7;
    localparam int ST_ERRL = 8;
    localparam int ST_BUSY = 13;

    typedef struct packed {
        logic [ERR_N-1:0] err;
        logic             ms;
        logic             en;
    } wsc_state_t;
endpackage

// File: rtl/wsc_cmd_decode.sv
module wsc_cmd_decode
    import wsc_pkg::*;
(
    input  logic                we_i,
    input  logic [CMD_W-1:0]    wdata_i,
    output logic [FLAG_N-1:0]   set_o,
    output logic [FLAG_N-1:0]   clr_o
);
    for (genvar i = 0; i < FLAG_N; i++) begin : g_pair
        assign set_o[i] = we_i & wdata_i[SET_POS[i]];
        assign clr_o[i] = we_i & wdata_i[CLR_POS[i]];
    end
endmodule

// File: rtl/wsc_flag_next.sv
module wsc_flag_next (
    input  logic cur_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    input  logic hw_hit_i,
    output logic nxt_o
);
    // software clear beats software set; a hardware hit beats everything
    always_comb begin
        nxt_o = cur_i;
        if (sw_set_i) nxt_o = 1'b1;
        if (sw_clr_i) nxt_o = 1'b0;
        if (hw_hit_i) nxt_o = 1'b1;
    end
endmodule

// File: rtl/wsc_irq_merge.sv
module wsc_irq_merge #(
    parameter int N = 6
) (
    input  logic [N-1:0] flags_i,
    output logic         irq_o
);
    assign irq_o = |flags_i;
endmodule

// File: rtl/flag_cmd_status.sv
module flag_cmd_status
    import wsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic [ERR_N-1:0]  hw_evt,
    input  logic [GATE_N-1:0] hw_gate,
    input  logic              busy_in,
    output logic [STAT_W-1:0] status,
    output logic              err_irq
);
    wsc_state_t        st_d, st_q;
    logic [FLAG_N-1:0] set_v, clr_v, hit_v, nxt_v;

    wsc_cmd_decode u_dec (
        .we_i    (cmd_we),
        .wdata_i (cmd_wdata),
        .set_o   (set_v),
        .clr_o   (clr_v)
    );

    assign hit_v[0] = 1'b0;
    assign hit_v[1] = 1'b0;
    assign hit_v[2] = hw_evt[0];
    for (genvar k = 1; k < ERR_N; k++) begin : g_gate
        assign hit_v[k+2] = hw_evt[k] & hw_gate[k-1];
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_cell
        wsc_flag_next u_cell (
            .cur_i    (st_q[i]),
            .sw_set_i (set_v[i]),
            .sw_clr_i (clr_v[i]),
            .hw_hit_i (hit_v[i]),
            .nxt_o    (nxt_v[i])
        );
    end

    always_comb begin
        st_d = wsc_state_t'(nxt_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status                          = '0;
        status[ST_EN]                   = st_q.en;
        status[ST_MS]                   = st_q.ms;
        status[ST_MODE]                 = st_q.err[0];
        status[ST_ERRL+GATE_N-1:ST_ERRL] = st_q.err[ERR_N-1:1];
        status[ST_BUSY]                 = busy_in;
    end

    wsc_irq_merge #(.N(ERR_N)) u_irq (
        .flags_i (st_q.err),
        .irq_o   (err_irq)
    );

    assert_set_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[1] && !cmd_wdata[0]) |=> status[ST_EN]);

    assert_clr_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[0]) |=> !status[ST_EN]);

    assert_sticky_txovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_ERRL] && !(cmd_we && cmd_wdata[8])) |=> status[ST_ERRL]);

    assert_gate_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[ST_ERRL] && hw_evt[1] && !hw_gate[0] &&
         !(cmd_we && cmd_wdata[12])) |=> !status[ST_ERRL]);

    assert_evt_beats_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt[1] && hw_gate[0]) |=> status[ST_ERRL]);

    assert_irq_on_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt[0] |=> err_irq);

    assert_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we) |=> $stable(status[ST_MS:ST_EN]));
endmodule

// File: tb/tb_flag_cmd_status.sv
`timescale 1ns/1ps
module tb_flag_cmd_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [5:0]  hw_evt = '0;
    logic [4:0]  hw_gate = '0;
    logic        busy_in = 1'b0;
    logic [15:0] status;
    logic        err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flag_cmd_status dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .hw_evt(hw_evt), .hw_gate(hw_gate), .busy_in(busy_in),
        .status(status), .err_irq(err_irq)
    );

    typedef struct packed {
        logic        we;
        logic [15:0] wd;
        logic [5:0]  ev;
        logic [4:0]  gt;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'h0002, 6'h00, 5'h00, 16'h0001},  // R2 set enable
        '{1'b1, 16'h0008, 6'h00, 5'h00, 16'h0003},  // R2 set master-select
        '{1'b1, 16'h0001, 6'h00, 5'h00, 16'h0002},  // R2 clear enable
        '{1'b1, 16'hF0A0, 6'h00, 5'h00, 16'h1F82},  // R3 set all errors
        '{1'b1, 16'h0F50, 6'h00, 5'h00, 16'h0002},  // R3 clear all errors
        '{1'b1, 16'h00C3, 6'h00, 5'h00, 16'h0002},  // R4 set+clear pairs
        '{1'b0, 16'h0002, 6'h00, 5'h00, 16'h0002},  // R10 no strobe
        '{1'b0, 16'h0000, 6'h01, 5'h00, 16'h0082},  // R6 mode ungated
        '{1'b0, 16'h0000, 6'h3E, 5'h00, 16'h0082},  // R6 gates closed
        '{1'b0, 16'h0000, 6'h02, 5'h01, 16'h0182},  // R6 tx overflow gated in
        '{1'b1, 16'h0002, 6'h00, 5'h00, 16'h0183},  // R5 sticky through write
        '{1'b1, 16'h0100, 6'h02, 5'h01, 16'h0183},  // R7 event beats clear
        '{1'b1, 16'h0110, 6'h20, 5'h10, 16'h1083},  // R7 rx underflow, R3 tx clr
        '{1'b1, 16'h0F55, 6'h00, 5'h00, 16'h0000}   // R3 clear everything
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset status", status, 16'h0000);
        check("R1 reset irq", {15'd0, err_irq}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", status, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            cmd_we = VEC[i].we; cmd_wdata = VEC[i].wd;
            hw_evt = VEC[i].ev; hw_gate = VEC[i].gt;
            @(negedge clk);
            cmd_we = 1'b0; cmd_wdata = '0; hw_evt = '0; hw_gate = '0;
            check($sformatf("R2-row%0d status", i), status, VEC[i].exp);
            check("R8 irq level", {15'd0, err_irq}, {15'd0, |VEC[i].exp[12:7]});
        end

        // R8: enable/master-select alone raise no interrupt
        cmd_we = 1'b1; cmd_wdata = 16'h000A;
        @(negedge clk); cmd_we = 1'b0;
        check("R8 no irq from control bits", {status[1:0], 13'd0, err_irq}, {2'b11, 14'd0});

        // R9: busy passthrough, same cycle
        busy_in = 1'b1; #1;
        check("R9 busy bit", status, 16'h2003);
        busy_in = 1'b0; #1;
        check("R9 busy low", status, 16'h0003);

        // R4/R9: alternating pattern, clear wins and spare bits stay 0
        @(negedge clk);
        cmd_we = 1'b1; cmd_wdata = 16'hAAAA;
        @(negedge clk); cmd_we = 1'b0;
        check("R4 R9 alternating write", status, 16'h1083);

        // R5: events on other flags and unrelated clears keep the flag
        cmd_we = 1'b1; cmd_wdata = 16'h0E00;
        @(negedge clk); cmd_we = 1'b0;
        check("R5 unrelated clears", status, 16'h1083);

        // R1: reset in the middle of operation
        rst_n = 1'b0; #1;
        check("R1 async reset", {status[12:0], 2'b00, err_irq}, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 held zero", status, 16'h0000);

        finish_run();
    end
endmodule